// File: doc/BRIEF.md
# Ethernet Address Lookup Table

This block keeps the forwarding table of a small three-port switch. Each entry can be a free slot, a MAC address entry, a VLAN entry or a VLAN-plus-address entry. An address entry is either unicast, naming one destination port, or multicast, carrying a port mask. Software fills and inspects the table one whole entry at a time. It stages the entry in three 32-bit data words and then issues a load or commit command carrying the entry index. A global control word enables the engine, clears the whole table and holds a VLAN-mode bit. Each port has a 2-bit state register.

Forwarding logic asks the table about a destination address on the lookup port. A scanner walks the entries in index order and examines one per clock. The first address entry whose MAC equals the destination wins. The result is a hit flag, the matched index and an egress port mask. When no entry matches, the frame floods to every port except the one it arrived on. In every case, ports that are not in the forwarding state are removed from the mask.

Top module: `mac_lookup_table`

## Requirements
- R1: After reset every register reads zero, the engine is disabled, all ports are disabled, every entry is free, and `lk_busy` and `lk_done` are low.
- R2: Register word addresses are: 0 control, 1 table command, 2/3/4 data words 0/1/2, 5/6/7 port state 0/1/2. An entry holds 69 bits. Data word 0 bits 4:0 carry entry bits 68:64, word 1 carries bits 63:32 and word 2 carries bits 31:0. Writing the command register with bit 31 clear copies the entry at the index in bits 3:0 into the data words. Writing it with bit 31 set stores the data words into that entry. The command register reads back the last index written.
- R3: Control bit 31 enables lookups and bit 2 is the VLAN-mode bit; both read back. Writing bit 30 as one turns every entry to free in that write cycle, and bit 30 always reads zero.
- R4: While the engine is disabled, a lookup request starts no scan and produces no `lk_done`.
- R5: Only entries of type 1 (address) or 3 (VLAN plus address) match, with the type in bits 61:60 and the MAC in bits 47:0. Free and VLAN-only entries are skipped even if their MAC bits equal the destination. When several entries match, the lowest index wins.
- R6: If `lk_start` is sampled at edge 0 and the first match is at index i, `lk_done` is high for exactly one cycle after edge i+1. On a miss, it is high after edge N_ENTRIES, with `lk_hit` low and `lk_index` zero. `lk_busy` is high from edge 0 until done.
- R7: For a unicast hit (entry bit 40 clear), the mask is the single port named in bits 67:66. If the blocked bit 65 is set, the mask is empty.
- R8: For a multicast hit (entry bit 40 set), the mask is the port mask in bits 68:66.
- R9: On a miss, the mask holds every port except the ingress port.
- R10: Port state registers hold 2 bits: 0 disabled, 1 blocked, 2 learning, 3 forwarding. Only ports in state 3 can appear in any result mask.
- R11: A lookup request made while a scan is running is ignored. The running scan finishes with its own address and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_start | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination MAC, first byte in bits 47:40 |
| lk_ingress | input | 2 | Port the frame arrived on |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle result strobe |
| lk_hit | output | 1 | Matching entry found |
| lk_index | output | 4 | Index of the matching entry |
| lk_mask | output | 3 | Egress port mask |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` at the falling edge after setting the address. Register writes and commands take effect at the following rising edge. For every lookup, the bench counts rising edges from the edge that samples `lk_start` up to the first falling edge at which `lk_done` is seen. It then compares that count with index+1 for a hit and with N_ENTRIES for a miss, so a scan that runs late, runs early or repeats an entry shows up as a wrong count. Hit, index and mask are read in that same done cycle. The disabled-engine case waits longer than a full scan and checks that no strobe appears.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
    localparam int WORD_W    = 32;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;
    localparam int KIND_LSB  = 60;
    localparam int BLOCK_BIT = 65;
    localparam int PORT_LSB  = 66;

    typedef enum logic [1:0] {
        EK_FREE      = 2'd0,
        EK_ADDR      = 2'd1,
        EK_VLAN      = 2'd2,
        EK_VLAN_ADDR = 2'd3
    } entry_kind_e;

    typedef enum logic [1:0] {
        PS_OFF     = 2'd0,
        PS_BLOCK   = 2'd1,
        PS_LEARN   = 2'd2,
        PS_FORWARD = 2'd3
    } port_state_e;
endpackage

// File: rtl/mlt_entry_store.sv
module mlt_entry_store #(
    parameter int N_ENTRIES = 16,
    parameter int ENTRY_W   = 69,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [ENTRY_W-1:0] rd_data,
    input  logic [IDX_W-1:0]   scan_idx,
    output logic [ENTRY_W-1:0] scan_data
);
    logic [ENTRY_W-1:0] mem_d [N_ENTRIES];
    logic [ENTRY_W-1:0] mem_q [N_ENTRIES];

    always_comb begin
        mem_d = mem_q;
        if (clr) begin
            for (int i = 0; i < N_ENTRIES; i++) mem_d[i] = '0;
        end else if (we) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data   = mem_q[rd_idx];
    assign scan_data = mem_q[scan_idx];
endmodule

// File: rtl/mlt_mask_resolve.sv
module mlt_mask_resolve #(
    parameter int NUM_PORTS = 3
) (
    input  logic                 hit,
    input  logic                 is_group,
    input  logic                 blocked,
    input  logic [1:0]           port_num,
    input  logic [NUM_PORTS-1:0] group_mask,
    input  logic [1:0]           ingress,
    input  logic [NUM_PORTS-1:0] fwd,
    output logic [NUM_PORTS-1:0] mask
);
    logic [NUM_PORTS-1:0] raw;

    always_comb begin
        if (hit) begin
            if (is_group)     raw = group_mask;
            else if (blocked) raw = '0;
            else              raw = NUM_PORTS'(1) << port_num;
        end else begin
            raw = ~(NUM_PORTS'(1) << ingress);
        end
        mask = raw & fwd;
    end
endmodule

// File: rtl/mlt_scanner.sv
module mlt_scanner
    import mlt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int NUM_PORTS = 3,
    parameter int ENTRY_W   = 69,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 start,
    input  logic [MAC_W-1:0]     mac,
    input  logic [1:0]           ingress,
    input  logic [NUM_PORTS-1:0] fwd,
    input  logic [ENTRY_W-1:0]   entry,
    output logic [IDX_W-1:0]     scan_idx,
    output logic                 busy,
    output logic                 done,
    output logic                 hit,
    output logic [IDX_W-1:0]     index,
    output logic [NUM_PORTS-1:0] mask,
    output logic [1:0]           cur_ingress
);
    typedef struct packed {
        logic                 busy;
        logic [IDX_W-1:0]     idx;
        logic [MAC_W-1:0]     mac;
        logic [1:0]           ing;
        logic                 done;
        logic                 hit;
        logic [IDX_W-1:0]     index;
        logic [NUM_PORTS-1:0] mask;
    } scan_t;

    scan_t s_d, s_q;
    entry_kind_e          kind;
    logic                 match;
    logic [NUM_PORTS-1:0] res_mask;
    logic                 unused_fields;

    assign kind  = entry_kind_e'(entry[KIND_LSB +: 2]);
    assign match = s_q.busy && (kind == EK_ADDR || kind == EK_VLAN_ADDR)
                   && (entry[MAC_W-1:0] == s_q.mac);
    assign unused_fields = ^{entry[BLOCK_BIT-1:MAC_W], entry[GROUP_BIT-1:0]};

    mlt_mask_resolve #(.NUM_PORTS(NUM_PORTS)) u_resolve (
        .hit        (match),
        .is_group   (entry[GROUP_BIT]),
        .blocked    (entry[BLOCK_BIT]),
        .port_num   (entry[PORT_LSB +: 2]),
        .group_mask (entry[PORT_LSB +: NUM_PORTS]),
        .ingress    (s_q.ing),
        .fwd        (fwd),
        .mask       (res_mask)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (match) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.hit   = 1'b1;
                s_d.index = s_q.idx;
                s_d.mask  = res_mask;
            end else if (s_q.idx == IDX_W'(N_ENTRIES - 1)) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.hit   = 1'b0;
                s_d.index = '0;
                s_d.mask  = res_mask;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (start && enable) begin
            s_d.busy = 1'b1;
            s_d.idx  = '0;
            s_d.mac  = mac;
            s_d.ing  = ingress;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scan_idx    = s_q.idx;
    assign busy        = s_q.busy;
    assign done        = s_q.done;
    assign hit         = s_q.hit;
    assign index       = s_q.index;
    assign mask        = s_q.mask;
    assign cur_ingress = s_q.ing;
endmodule

// File: rtl/mac_lookup_table.sv
module mac_lookup_table
    import mlt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 4,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 lk_start,
    input  logic [MAC_W-1:0]     lk_mac,
    input  logic [1:0]           lk_ingress,
    output logic                 lk_busy,
    output logic                 lk_done,
    output logic                 lk_hit,
    output logic [IDX_W-1:0]     lk_index,
    output logic [NUM_PORTS-1:0] lk_mask
);
    localparam int ENTRY_W = PORT_LSB + NUM_PORTS;
    localparam int HI_W    = ENTRY_W - 2 * WORD_W;
    localparam int A_CTRL  = 0;
    localparam int A_CMD   = 1;
    localparam int A_DATA  = 2;
    localparam int A_PORT  = 5;

    typedef struct packed {
        logic                       en;
        logic                       vlan;
        logic [IDX_W-1:0]           idx;
        logic [2:0][WORD_W-1:0]     data;
        logic [NUM_PORTS-1:0][1:0]  pst;
    } regs_t;

    regs_t r_d, r_q;
    logic                 clr, commit, load;
    logic [ENTRY_W-1:0]   rd_entry, scan_entry, wr_entry;
    logic [IDX_W-1:0]     scan_idx;
    logic [NUM_PORTS-1:0] fwd_ports;
    logic [1:0]           scan_ing;
    int                   a;

    assign a        = int'(reg_addr);
    assign wr_entry = {r_q.data[0][HI_W-1:0], r_q.data[1], r_q.data[2]};

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fwd
            assign fwd_ports[p] = (port_state_e'(r_q.pst[p]) == PS_FORWARD);
        end
    endgenerate

    always_comb begin
        r_d    = r_q;
        clr    = 1'b0;
        commit = 1'b0;
        load   = 1'b0;
        if (reg_we) begin
            if (a == A_CTRL) begin
                r_d.en   = reg_wdata[31];
                r_d.vlan = reg_wdata[2];
                clr      = reg_wdata[30];
            end else if (a == A_CMD) begin
                r_d.idx = reg_wdata[IDX_W-1:0];
                commit  = reg_wdata[31];
                load    = !reg_wdata[31];
            end
            for (int w = 0; w < 3; w++)
                if (a == A_DATA + w) r_d.data[w] = reg_wdata;
            for (int p = 0; p < NUM_PORTS; p++)
                if (a == A_PORT + p) r_d.pst[p] = reg_wdata[1:0];
        end
        if (load) begin
            r_d.data[0] = WORD_W'(rd_entry[ENTRY_W-1:2*WORD_W]);
            r_d.data[1] = rd_entry[2*WORD_W-1:WORD_W];
            r_d.data[2] = rd_entry[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (a == A_CTRL) reg_rdata = {r_q.en, 1'b0, 27'd0, r_q.vlan, 2'd0};
        if (a == A_CMD)  reg_rdata = WORD_W'(r_q.idx);
        for (int w = 0; w < 3; w++)
            if (a == A_DATA + w) reg_rdata = r_q.data[w];
        for (int p = 0; p < NUM_PORTS; p++)
            if (a == A_PORT + p) reg_rdata = WORD_W'(r_q.pst[p]);
    end

    mlt_entry_store #(.N_ENTRIES(N_ENTRIES), .ENTRY_W(ENTRY_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .we        (commit),
        .wr_idx    (reg_wdata[IDX_W-1:0]),
        .wr_data   (wr_entry),
        .rd_idx    (reg_wdata[IDX_W-1:0]),
        .rd_data   (rd_entry),
        .scan_idx  (scan_idx),
        .scan_data (scan_entry)
    );

    mlt_scanner #(.N_ENTRIES(N_ENTRIES), .NUM_PORTS(NUM_PORTS), .ENTRY_W(ENTRY_W)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (r_q.en),
        .start       (lk_start),
        .mac         (lk_mac),
        .ingress     (lk_ingress),
        .fwd         (fwd_ports),
        .entry       (scan_entry),
        .scan_idx    (scan_idx),
        .busy        (lk_busy),
        .done        (lk_done),
        .hit         (lk_hit),
        .index       (lk_index),
        .mask        (lk_mask),
        .cur_ingress (scan_ing)
    );
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
    parameter int NUM_PORTS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 done,
    input logic                 hit,
    input logic [NUM_PORTS-1:0] mask,
    input logic [NUM_PORTS-1:0] fwd,
    input logic [1:0]           ingress
);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !done);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    fwd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mask & ~$past(fwd)) == '0));

    // R9
    miss_ingress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (mask[ingress] == 1'b0));
endmodule

bind mac_lookup_table mlt_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (lk_busy),
    .done    (lk_done),
    .hit     (lk_hit),
    .mask    (lk_mask),
    .fwd     (fwd_ports),
    .ingress (scan_ing)
);

// File: tb/test_mac_lookup_table.sv
module test_mac_lookup_table;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_start = 1'b0;
    logic [47:0] lk_mac = '0;
    logic [1:0]  lk_ingress = '0;
    logic        lk_busy, lk_done, lk_hit;
    logic [3:0]  lk_index;
    logic [2:0]  lk_mask;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mac_lookup_table i_mac_lookup_table (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_start(lk_start),
        .lk_mac(lk_mac), .lk_ingress(lk_ingress), .lk_busy(lk_busy),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_index(lk_index), .lk_mask(lk_mask)
    );

    typedef struct packed {
        logic [47:0] mac;
        logic [1:0]  ing;
        logic        hit;
        logic [3:0]  idx;
        logic [2:0]  mask;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{48'h02_11_22_33_44_55, 2'd0, 1'b1, 4'd2,  3'b010},  // R7 unicast, R5 lowest index
        '{48'h02_AA_00_00_00_01, 2'd0, 1'b1, 4'd5,  3'b100},  // R5 skips VLAN-only
        '{48'h01_00_5E_00_00_01, 2'd1, 1'b1, 4'd7,  3'b101},  // R8 multicast
        '{48'h02_BB_00_00_00_02, 2'd0, 1'b1, 4'd9,  3'b000},  // R7 blocked
        '{48'h02_CC_00_00_00_03, 2'd1, 1'b0, 4'd0,  3'b101},  // R5 free skipped, R9 miss
        '{48'h02_DD_00_00_00_0F, 2'd2, 1'b1, 4'd15, 3'b001},  // R6 last entry
        '{48'h0F_FF_FF_FF_FF_FF, 2'd2, 1'b0, 4'd0,  3'b011}   // R9 miss
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = addr;
        #1 data = reg_rdata;
    endtask

    function automatic logic [68:0] mk(input logic [1:0] ty, input logic [47:0] mac,
                                       input logic [4:0] hi);
        return {hi, 2'b00, ty, 12'd0, mac};
    endfunction

    task automatic put_entry(input int idx, input logic [68:0] e);
        reg_write(4'd2, {27'd0, e[68:64]});
        reg_write(4'd3, e[63:32]);
        reg_write(4'd4, e[31:0]);
        reg_write(4'd1, 32'h8000_0000 | 32'(idx));
    endtask

    task automatic lookup(input logic [47:0] mac, input logic [1:0] ing,
                          output int cycles);
        @(negedge clk);
        lk_start = 1'b1; lk_mac = mac; lk_ingress = ing;
        @(posedge clk);
        @(negedge clk);
        lk_start = 1'b0;
        cycles = 0;
        for (int c = 1; c <= N + 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (lk_done) begin cycles = c; break; end
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            reg_read(4'(a), rd);
            check("R1 reg", 64'(rd), 64'd0);
        end
        check("R1 busy/done", {62'd0, lk_busy, lk_done}, 64'd0);

        // R4: disabled engine ignores requests
        lookup(48'h02_11_22_33_44_55, 2'd0, cyc);
        check("R4 no done", 64'(cyc), 64'd0);
        check("R4 not busy", 64'(lk_busy), 64'd0);

        // R2: commit, overwrite, load back
        put_entry(2, mk(2'd1, 48'h02_11_22_33_44_55, 5'b00100));
        reg_write(4'd2, 32'hFFFF_FFE4);
        reg_write(4'd3, 32'h1234_5678);
        reg_write(4'd4, 32'h9ABC_DEF0);
        reg_write(4'd1, 32'd2);
        reg_read(4'd2, rd); check("R2 word0", 64'(rd), 64'h4);
        reg_read(4'd3, rd); check("R2 word1", 64'(rd), 64'h1000_0211);
        reg_read(4'd4, rd); check("R2 word2", 64'(rd), 64'h2233_4455);
        reg_read(4'd1, rd); check("R2 index", 64'(rd), 64'd2);

        // R3: control readback and clear
        reg_write(4'd0, 32'h8000_0004);
        reg_read(4'd0, rd); check("R3 ctrl", 64'(rd), 64'h8000_0004);
        reg_write(4'd0, 32'hC000_0004);
        reg_read(4'd0, rd); check("R3 clear reads 0", 64'(rd), 64'h8000_0004);
        reg_write(4'd1, 32'd2);
        reg_read(4'd3, rd); check("R3 cleared word1", 64'(rd), 64'd0);
        reg_read(4'd4, rd); check("R3 cleared word2", 64'(rd), 64'd0);

        // R10: port states
        for (int p = 0; p < 3; p++) reg_write(4'(5 + p), 32'hFFFF_FFFF);
        reg_read(4'd6, rd); check("R10 port state", 64'(rd), 64'd3);

        put_entry(2,  mk(2'd1, 48'h02_11_22_33_44_55, 5'b00100));
        put_entry(4,  mk(2'd2, 48'h02_AA_00_00_00_01, 5'b00000));
        put_entry(5,  mk(2'd3, 48'h02_AA_00_00_00_01, 5'b01000));
        put_entry(7,  mk(2'd1, 48'h01_00_5E_00_00_01, 5'b10100));
        put_entry(9,  mk(2'd1, 48'h02_BB_00_00_00_02, 5'b00010));
        put_entry(10, mk(2'd0, 48'h02_CC_00_00_00_03, 5'b00100));
        put_entry(12, mk(2'd1, 48'h02_11_22_33_44_55, 5'b01000));
        put_entry(15, mk(2'd1, 48'h02_DD_00_00_00_0F, 5'b00000));

        // R5 R6 R7 R8 R9: vector table
        foreach (VECS[k]) begin
            lookup(VECS[k].mac, VECS[k].ing, cyc);
            check("R6 latency", 64'(cyc), VECS[k].hit ? 64'(VECS[k].idx + 1) : 64'(N));
            check("R5 hit", 64'(lk_hit), 64'(VECS[k].hit));
            check("R5 index", 64'(lk_index), 64'(VECS[k].idx));
            check("R7 R8 R9 mask", 64'(lk_mask), 64'(VECS[k].mask));
            @(negedge clk);
            check("R6 done one cycle", 64'(lk_done), 64'd0);
        end

        // R10: learning port drops out of masks
        reg_write(4'd6, 32'd2);
        lookup(48'h02_11_22_33_44_55, 2'd0, cyc);
        check("R10 hit to learning port", 64'(lk_mask), 64'b000);
        lookup(48'h02_EE_00_00_00_00, 2'd0, cyc);
        check("R10 flood skips learning", 64'(lk_mask), 64'b100);
        reg_write(4'd6, 32'd3);

        // R11: request during a scan is ignored
        @(negedge clk);
        lk_start = 1'b1; lk_mac = 48'h02_DD_00_00_00_0F; lk_ingress = 2'd2;
        @(posedge clk);
        @(negedge clk);
        lk_start = 1'b0;
        cyc = 0;
        for (int c = 1; c <= N + 6; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (lk_done) begin cyc = c; break; end
            lk_start = (c == 3);
            if (c == 3) begin lk_mac = 48'h02_11_22_33_44_55; lk_ingress = 2'd0; end
        end
        lk_start = 1'b0;
        check("R11 latency", 64'(cyc), 64'd16);
        check("R11 index", 64'(lk_index), 64'd15);
        check("R11 mask", 64'(lk_mask), 64'b001);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule